// File: doc/BRIEF.md
# Oscillation Period Capture Counter

This block measures the ringing period of a switching node. It watches a filtered comparator event and counts selected transitions of it. It then counts clock cycles between two chosen transitions. An arming trigger starts a measurement. After the trigger, the transitions of the event that match the chosen polarity are numbered from one. Period counting begins on the transition whose number equals the start index. It ends on the transition whose number equals the stop index.

When counting ends, the cycle count is loaded into a held result register and a strobe fires for one cycle. The counter then clears, and the block locks out until the next trigger. A new trigger always discards any measurement in progress. While the enable input is low, the block does nothing.

Top module: `osc_period_cap`

## Requirements
- R1: While `rst_n` is low, `cap_val` is 0 and `cap_vld` is 0.
- R2: `edge_mode` selects which transitions of `evt_in` are counted: 2'b01 counts rising only, 2'b10 counts falling only, 2'b11 counts both, and 2'b00 counts none, so no capture can happen.
- R3: The selected transitions after a trigger are numbered from 1. When transition number `start_idx` and transition number `stop_idx` are sampled at clock edges D cycles apart, `cap_val` becomes D.
- R4: `cap_vld` is high for exactly one cycle, in the cycle after the stop transition's clock edge, together with the new `cap_val`. At all other times `cap_val` holds its value.
- R5: After a capture, further transitions produce no capture and leave `cap_val` unchanged until the next trigger.
- R6: A trigger during a measurement discards it. Transition numbering restarts at 1 after the trigger, and the period count restarts at 0.
- R7: While `cap_en` is low, triggers are ignored and any measurement in progress is abandoned without a capture.
- R8: A trigger that arrives while `start_idx` is 0, or while `stop_idx` is not greater than `start_idx`, leaves the block unarmed, so no capture follows.
- R9: If the interval reaches 2^CNT_W-1 cycles or more, `cap_val` saturates at 2^CNT_W-1 (0xFFFF by default).
- R10: A transition sampled in the same cycle as a trigger is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture logic enable |
| trig | input | 1 | Arming trigger, one cycle per event |
| evt_in | input | 1 | Filtered comparator event level |
| edge_mode | input | 2 | Transition polarity select (see R2) |
| start_idx | input | IDX_W (4) | Transition number that starts the count |
| stop_idx | input | IDX_W (4) | Transition number that stops the count |
| cap_val | output | CNT_W (16) | Held captured period in cycles |
| cap_vld | output | 1 | One-cycle strobe when cap_val updates |

## Verification
The bench checks the transition numbering under each polarity setting. A design that miscounted polarities, or started the count one transition off, would capture a period that differs from the gap sum the bench computes. The bench retriggers in the middle of a measurement and places a transition in the same cycle as a trigger. A design that kept stale transition counts, or counted that transition, would stop early with a short value. The bench also disables the block mid-run and applies invalid index pairs, where any strobe is a failure. It stretches one interval past 65535 cycles, where a wrapping counter would report a small number instead of the saturated maximum.

// File: rtl/ospc_pkg.sv
`timescale 1ns/1ps
package ospc_pkg;
   typedef enum logic [1:0] {
      EM_NONE = 2'b00,
      EM_RISE = 2'b01,
      EM_FALL = 2'b10,
      EM_BOTH = 2'b11
   } edge_mode_e;

   typedef enum logic [1:0] {
      TRK_IDLE  = 2'b00,
      TRK_ARMED = 2'b01,
      TRK_RUN   = 2'b10
   } trk_state_e;
endpackage

// File: rtl/ospc_edge_det.sv
`timescale 1ns/1ps
module ospc_edge_det
   import ospc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt_in,
   input  edge_mode_e mode,
   output logic       hit
);
   localparam int NPOL = 2;

   logic            evt_q;
   logic [NPOL-1:0] pol_seen;
   logic [NPOL-1:0] pol_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_in;
   end

   assign pol_mask = mode;

   // bit 0: rising transition, bit 1: falling transition
   for (genvar p = 0; p < NPOL; p++) begin : g_pol
      if (p == 0) begin : g_rise
         assign pol_seen[p] = pol_mask[p] & evt_in & ~evt_q;
      end else begin : g_fall
         assign pol_seen[p] = pol_mask[p] & ~evt_in & evt_q;
      end
   end

   assign hit = |pol_seen;
endmodule

// File: rtl/ospc_edge_track.sv
`timescale 1ns/1ps
module ospc_edge_track
   import ospc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             trig,
   input  logic             hit,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] stop_idx,
   output logic             run_clear,
   output logic             run_start,
   output logic             run_stop,
   output logic             running,
   output logic             idle
);
   trk_state_e       st_q;
   logic [IDX_W-1:0] ecnt_q;
   logic [IDX_W-1:0] ecnt_nxt;
   logic             cfg_ok;
   logic             take;

   assign cfg_ok    = (start_idx != '0) && (stop_idx > start_idx);
   assign ecnt_nxt  = IDX_W'(ecnt_q + 1'b1);
   assign run_clear = ~en | trig;
   assign take      = ~run_clear & hit & (st_q != TRK_IDLE);
   assign run_start = take & (st_q == TRK_ARMED) & (ecnt_nxt == start_idx);
   assign run_stop  = take & (st_q == TRK_RUN) & (ecnt_nxt == stop_idx);
   assign running   = (st_q == TRK_RUN);
   assign idle      = (st_q == TRK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TRK_IDLE;
         ecnt_q <= '0;
      end else if (!en) begin
         st_q   <= TRK_IDLE;
         ecnt_q <= '0;
      end else if (trig) begin
         ecnt_q <= '0;
         st_q   <= cfg_ok ? TRK_ARMED : TRK_IDLE;
      end else if (take) begin
         if (run_stop) begin
            st_q   <= TRK_IDLE;
            ecnt_q <= '0;
         end else begin
            ecnt_q <= ecnt_nxt;
            if (run_start) st_q <= TRK_RUN;
         end
      end
   end
endmodule

// File: rtl/ospc_period_ctr.sv
`timescale 1ns/1ps
module ospc_period_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_clear,
   input  logic             run_start,
   input  logic             run_stop,
   input  logic             running,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_vld
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] pcnt_q;
   logic [CNT_W-1:0] pcnt_inc;

   assign pcnt_inc = (pcnt_q == CNT_MAX) ? CNT_MAX : CNT_W'(pcnt_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q  <= '0;
         cap_val <= '0;
         cap_vld <= 1'b0;
      end else begin
         cap_vld <= 1'b0;
         if (run_clear || run_start) begin
            pcnt_q <= '0;
         end else if (run_stop) begin
            cap_val <= pcnt_inc;
            cap_vld <= 1'b1;
            pcnt_q  <= '0;
         end else if (running) begin
            pcnt_q <= pcnt_inc;
         end
      end
   end
endmodule

// File: rtl/osc_period_cap.sv
`timescale 1ns/1ps
module osc_period_cap
   import ospc_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             trig,
   input  logic             evt_in,
   input  logic [1:0]       edge_mode,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] stop_idx,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_vld
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("osc_period_cap: CNT_W must lie in 2..32");
   end
   if (IDX_W < 2 || IDX_W > 8) begin : g_bad_idx_w
      $error("osc_period_cap: IDX_W must lie in 2..8");
   end

   logic hit;
   logic run_clear;
   logic run_start;
   logic run_stop;
   logic running;
   logic trk_idle;

   ospc_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .mode   (edge_mode_e'(edge_mode)),
      .hit    (hit)
   );

   ospc_edge_track #(.IDX_W(IDX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cap_en),
      .trig      (trig),
      .hit       (hit),
      .start_idx (start_idx),
      .stop_idx  (stop_idx),
      .run_clear (run_clear),
      .run_start (run_start),
      .run_stop  (run_stop),
      .running   (running),
      .idle      (trk_idle)
   );

   ospc_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_clear (run_clear),
      .run_start (run_start),
      .run_stop  (run_stop),
      .running   (running),
      .cap_val   (cap_val),
      .cap_vld   (cap_vld)
   );
endmodule

// File: rtl/osc_period_cap_chk.sv
`timescale 1ns/1ps
module osc_period_cap_chk #(
   parameter int CNT_W = 16,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cap_en,
   input logic             trig,
   input logic [IDX_W-1:0] start_idx,
   input logic [IDX_W-1:0] stop_idx,
   input logic [CNT_W-1:0] cap_val,
   input logic             cap_vld,
   input logic             trk_idle
);
   // R1
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (cap_vld == 1'b0 && cap_val == '0));

   // R4
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |=> !cap_vld);

   // R4
   val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_vld |-> $stable(cap_val));

   // R7
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |-> $past(cap_en));

   // R5
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_idle && !(trig && cap_en)) |=> trk_idle);

   // R5
   cap_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |-> (trk_idle && !$past(trk_idle)));

   // R8
   bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && trig && (start_idx == '0 || stop_idx <= start_idx)) |=> trk_idle);

   // R3
   nonzero_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |-> (cap_val != '0));
endmodule

bind osc_period_cap osc_period_cap_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cap_en    (cap_en),
   .trig      (trig),
   .start_idx (start_idx),
   .stop_idx  (stop_idx),
   .cap_val   (cap_val),
   .cap_vld   (cap_vld),
   .trk_idle  (trk_idle)
);

// File: tb/osc_period_cap_bench.sv
`timescale 1ns/1ps
module osc_period_cap_bench;
   localparam int CNT_W = 16;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cap_en = 1'b0;
   logic             trig = 1'b0;
   logic             evt = 1'b0;
   logic [1:0]       edge_mode = 2'b11;
   logic [IDX_W-1:0] start_idx = '0;
   logic [IDX_W-1:0] stop_idx = '0;
   logic [CNT_W-1:0] cap_val;
   logic             cap_vld;

   int checks = 0;
   int errors = 0;
   int vld_seen = 0;
   bit done = 1'b0;
   string cur_req = "R3";
   int expq[$];

   always #2.5 clk = ~clk;

   osc_period_cap #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_osc_period_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .trig      (trig),
      .evt_in    (evt),
      .edge_mode (edge_mode),
      .start_idx (start_idx),
      .stop_idx  (stop_idx),
      .cap_val   (cap_val),
      .cap_vld   (cap_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every strobe
   always @(negedge clk) begin
      if (rst_n && cap_vld && !done) begin
         vld_seen++;
         if (expq.size() == 0) begin
            chk(1'b0, {cur_req, " unexpected capture"}, int'(cap_val), -1);
         end else begin
            int e;
            e = expq.pop_front();
            chk(int'(cap_val) == e, cur_req, int'(cap_val), e);
         end
      end
   end

   task automatic tog(input int gap);
      repeat (gap) @(negedge clk);
      evt = ~evt;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic prep(input logic [1:0] m, input int s, input int p);
      @(negedge clk);
      evt = 1'b0;
      edge_mode = m;
      start_idx = IDX_W'(s);
      stop_idx = IDX_W'(p);
      repeat (2) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   initial begin
      int seen0;
      int held;
      repeat (3) @(negedge clk);
      // R1: outputs cleared during reset
      chk(cap_val == '0, "R1 cap_val", int'(cap_val), 0);
      chk(cap_vld == 1'b0, "R1 cap_vld", int'(cap_vld), 0);
      rst_n = 1'b1;
      cap_en = 1'b1;

      // R3: both polarities, start 1, stop 3, D = 4 + 5
      cur_req = "R3";
      prep(2'b11, 1, 3);
      expq.push_back(9);
      tog(2); tog(4); tog(5);
      @(negedge clk);
      chk(cap_vld == 1'b1, "R4 strobe high", int'(cap_vld), 1);
      @(negedge clk);
      chk(cap_vld == 1'b0, "R4 strobe single cycle", int'(cap_vld), 0);
      chk(cap_val == 16'd9, "R4 value held", int'(cap_val), 9);

      // R5: lockout after capture
      cur_req = "R5";
      seen0 = vld_seen;
      repeat (6) tog(3);
      settle();
      chk(vld_seen == seen0, "R5 no capture after lockout", vld_seen - seen0, 0);
      chk(cap_val == 16'd9, "R5 value unchanged", int'(cap_val), 9);

      // R2: rising only, start 2, stop 3, D = 4 + 3
      cur_req = "R2 rising";
      prep(2'b01, 2, 3);
      expq.push_back(7);
      tog(1); tog(3); tog(2); tog(4); tog(3);
      settle();

      // R2: falling only, start 1, stop 2, D = 5 + 6
      cur_req = "R2 falling";
      prep(2'b10, 1, 2);
      expq.push_back(11);
      tog(2); tog(2); tog(5); tog(6);
      settle();

      // R2: no polarity selected
      cur_req = "R2 none";
      seen0 = vld_seen;
      prep(2'b00, 1, 2);
      repeat (6) tog(2);
      settle();
      chk(vld_seen == seen0, "R2 mode none gives no capture", vld_seen - seen0, 0);

      // R6: retrigger mid-run, then D = 2 + 4
      cur_req = "R6";
      prep(2'b11, 1, 3);
      tog(2); tog(3);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      expq.push_back(6);
      tog(2); tog(2); tog(4);
      settle();

      // R10: transition in trigger cycle not counted, D = 5
      cur_req = "R10";
      @(negedge clk);
      evt = 1'b0; edge_mode = 2'b11; start_idx = 4'd1; stop_idx = 4'd2;
      repeat (2) @(negedge clk);
      trig = 1'b1; evt = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      expq.push_back(5);
      tog(3); tog(5);
      settle();

      // R7: disable mid-run abandons it
      cur_req = "R7";
      held = int'(cap_val);
      seen0 = vld_seen;
      prep(2'b11, 1, 2);
      tog(2);
      @(negedge clk); cap_en = 1'b0;
      @(negedge clk); cap_en = 1'b1;
      tog(3); tog(3);
      settle();
      chk(vld_seen == seen0, "R7 abandoned run", vld_seen - seen0, 0);
      // R7: trigger while disabled is ignored
      @(negedge clk); cap_en = 1'b0; trig = 1'b1;
      @(negedge clk); trig = 1'b0; cap_en = 1'b1;
      tog(2); tog(2); tog(2);
      settle();
      chk(vld_seen == seen0, "R7 trigger ignored when disabled", vld_seen - seen0, 0);
      chk(int'(cap_val) == held, "R7 value unchanged", int'(cap_val), held);

      // R8: invalid index pairs
      cur_req = "R8";
      prep(2'b11, 3, 3);
      repeat (5) tog(2);
      settle();
      chk(vld_seen == seen0, "R8 stop equal start", vld_seen - seen0, 0);
      prep(2'b11, 0, 2);
      repeat (5) tog(2);
      settle();
      chk(vld_seen == seen0, "R8 start zero", vld_seen - seen0, 0);
      prep(2'b11, 5, 2);
      repeat (6) tog(2);
      settle();
      chk(vld_seen == seen0, "R8 stop below start", vld_seen - seen0, 0);

      // R9: saturation
      cur_req = "R9";
      prep(2'b11, 1, 2);
      expq.push_back(65535);
      tog(1); tog(70000);
      settle();
      chk(cap_val == 16'hFFFF, "R9 saturated value", int'(cap_val), 65535);

      chk(expq.size() == 0, "R3 missing captures", expq.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule